// File: doc/BRIEF.md
# Sync-Gated Receive Bit FIFO

This block gathers the bits of a received data stream into a sixteen-bit first-in first-out store. A bit is taken only in a cycle where the bit strobe from the clock recovery logic is high. The fill-enable control decides whether the store accepts bits at all. When it is set, a mode input picks between two start conditions. In one, the block waits until the sixteen-bit word 0x2DD4 has been seen in the stream. In the other, it stores every strobed bit at once. Once the pattern has been found, the block stays locked onto the stream. A new search starts only when fill-enable has been dropped and then raised again.

A host takes data out one byte at a time through a read request. The byte holds the oldest stored bit in its most significant position. Two flags go back to the host. The level flag is high while the number of stored bits is at or above a four-bit threshold. The overflow flag reports a bit that was lost because the store was full. The store is held empty while either the receiver-enable input or the FIFO-enable input is low.

A three-state controller runs the pattern search. Its states are HUNT_OFF (fill disabled), HUNT_SEEK (looking for the pattern) and HUNT_LOCK (pattern found, bits are stored). HUNT_OFF moves to HUNT_SEEK when fill-enable is high. HUNT_SEEK moves to HUNT_LOCK on a strobe that completes the pattern. HUNT_SEEK or HUNT_LOCK moves back to HUNT_OFF when fill-enable is low, when rx_en or fifo_en goes low, or on reset.

Top module: `sync_bit_fifo`

## Requirements
- R1: After reset, and in the cycle after either `rx_en` or `fifo_en` is seen low, the store holds no bits, `ovf_flag` is 0, and the search is back in HUNT_OFF.
- R2: With `fill_always`=0 and `fill_en`=1, no bit is stored until the last 16 strobed bits, oldest first, equal 0x2DD4. The bit that completes the pattern is not stored. Every strobed bit after it is stored.
- R3: After the pattern has been found, the lock holds while `fill_en` stays 1. Later bits are stored even if they form the pattern again.
- R4: While `fill_en` is 0, no bit is stored. When `fill_en` is raised again, a pattern completed while hunting is needed before bits are stored (with `fill_always`=0).
- R5: With `fill_always`=1 and `fill_en`=1, every strobed bit is stored without any pattern.
- R6: A change on `rx_bit` while `bit_stb` is 0 has no effect on the stored data.
- R7: `level_flag` is 1 exactly when the number of stored bits is greater than or equal to `irq_level`. It follows each write or read from the next cycle.
- R8: The store holds at most 16 bits. A bit that arrives while 16 are stored, with no read in the same cycle, is dropped. It sets `ovf_flag`, and the stored bits stay unchanged.
- R9: `ovf_flag` stays set until the next byte read or clear.
- R10: A read request loads `rd_byte`, valid from the next cycle, with the 8 oldest stored bits. The earliest received of these is in bit 7. The read also removes those 8 bits from the store.
- R11: A read with fewer than 8 bits stored returns them left-aligned with zeros below them, and leaves the store empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Recovered data bit |
| bit_stb | input | 1 | One-cycle strobe qualifying `rx_bit` |
| rx_en | input | 1 | Receiver enable; low clears the block |
| fifo_en | input | 1 | FIFO enable; low clears the block |
| fill_en | input | 1 | Fill enable; a fall followed by a rise re-arms the search |
| fill_always | input | 1 | 1 = store without a pattern, 0 = wait for 0x2DD4 |
| irq_level | input | 4 | Threshold for the level flag, counted in bits |
| rd_req | input | 1 | Pop one byte |
| rd_byte | output | 8 | Last popped byte, MSB is the oldest bit |
| level_flag | output | 1 | Stored bit count is at or above `irq_level` |
| ovf_flag | output | 1 | A bit was lost because the store was full |

## Verification
Some properties are checked on every cycle by assertions. These cover the count bound, the setting of the overflow flag, the stored bits staying frozen on an overflow, the clear, the emptying by a short read, and the stay-or-leave rules of the search controller. Other behaviour can only be seen at the ports over a whole scenario, so the directed scenarios cover it. This includes the exact bit where a pattern completes, the need for a fresh pattern after re-arming, MSB-first byte order, zero padding and the threshold compare.

// File: rtl/sync_bit_fifo_pkg.sv
package sync_bit_fifo_pkg;
    typedef enum logic [1:0] {
        HUNT_OFF  = 2'd0,
        HUNT_SEEK = 2'd1,
        HUNT_LOCK = 2'd2
    } hunt_state_t;
endpackage

// File: rtl/sync_hunter.sv
module sync_hunter
    import sync_bit_fifo_pkg::*;
#(
    parameter int          SYNC_W    = 16,
    parameter logic [15:0] SYNC_WORD = 16'h2DD4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic fill_en,
    input  logic bit_stb,
    input  logic rx_bit,
    output logic locked
);
    hunt_state_t       state, state_nx;
    logic [SYNC_W-1:0] win_q;
    logic [SYNC_W-1:0] win_nx;
    logic              hit;

    assign win_nx = {win_q[SYNC_W-2:0], rx_bit};
    assign hit    = bit_stb && (win_nx == SYNC_W'(SYNC_WORD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       win_q <= '0;
        else if (clr)     win_q <= '0;
        else if (bit_stb) win_q <= win_nx;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= HUNT_OFF;
        else if (clr) state <= HUNT_OFF;
        else          state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            HUNT_OFF:  if (fill_en) state_nx = HUNT_SEEK;
            HUNT_SEEK: if (!fill_en) state_nx = HUNT_OFF;
                       else if (hit) state_nx = HUNT_LOCK;
            HUNT_LOCK: if (!fill_en) state_nx = HUNT_OFF;
            default:   state_nx = HUNT_OFF;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            HUNT_LOCK: locked = 1'b1;
            default:   locked = 1'b0;
        endcase
    end

    // R4
    hunt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_en) |=> (state == HUNT_OFF));

    // R3
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && fill_en && state == HUNT_LOCK) |=> (state == HUNT_LOCK));

    // R1
    hunt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (state == HUNT_OFF));
endmodule

// File: rtl/bit_store.sv
module bit_store #(
    parameter int DEPTH = 16,
    parameter int RD_W  = 8,
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_req,
    input  logic [LVL_W-1:0] irq_level,
    output logic [RD_W-1:0]  rd_byte,
    output logic             level_flag,
    output logic             ovf_flag
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] mem, mem_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             ovf_nx;
    logic             drop;

    always_comb begin
        mem_nx = mem;
        cnt_nx = cnt;
        if (rd_req) begin
            mem_nx = mem << RD_W;
            cnt_nx = (cnt >= CNT_W'(RD_W)) ? cnt - CNT_W'(RD_W) : '0;
        end
        drop = wr_en && (cnt_nx == CNT_W'(DEPTH));
        if (wr_en && !drop) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CNT_W'(DEPTH - 1 - i) == cnt_nx) mem_nx[i] = wr_bit;
            end
            cnt_nx = cnt_nx + 1'b1;
        end
        if (drop)        ovf_nx = 1'b1;
        else if (rd_req) ovf_nx = 1'b0;
        else             ovf_nx = ovf_flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem      <= '0;
            cnt      <= '0;
            ovf_flag <= 1'b0;
            rd_byte  <= '0;
        end else if (clr) begin
            mem      <= '0;
            cnt      <= '0;
            ovf_flag <= 1'b0;
        end else begin
            mem      <= mem_nx;
            cnt      <= cnt_nx;
            ovf_flag <= ovf_nx;
            if (rd_req) rd_byte <= mem[DEPTH-1 -: RD_W];
        end
    end

    assign level_flag = (cnt >= CNT_W'(irq_level));

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && wr_en && !rd_req && cnt == CNT_W'(DEPTH)) |=> ovf_flag);

    // R8
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && wr_en && !rd_req && cnt == CNT_W'(DEPTH)) |=> $stable(mem));

    // R1
    store_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && !ovf_flag));

    // R11
    short_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && rd_req && !wr_en && cnt < CNT_W'(RD_W)) |=> (cnt == '0));
endmodule

// File: rtl/sync_bit_fifo.sv
module sync_bit_fifo #(
    parameter int          DEPTH     = 16,
    parameter int          RD_W      = 8,
    parameter int          LVL_W     = 4,
    parameter int          SYNC_W    = 16,
    parameter logic [15:0] SYNC_WORD = 16'h2DD4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             bit_stb,
    input  logic             rx_en,
    input  logic             fifo_en,
    input  logic             fill_en,
    input  logic             fill_always,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             rd_req,
    output logic [RD_W-1:0]  rd_byte,
    output logic             level_flag,
    output logic             ovf_flag
);
    logic clr;
    logic locked;
    logic wr_en;

    assign clr   = !rx_en || !fifo_en;
    assign wr_en = bit_stb && fill_en && (fill_always || locked) && !clr;

    sync_hunter #(
        .SYNC_W    (SYNC_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_hunt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .fill_en (fill_en),
        .bit_stb (bit_stb),
        .rx_bit  (rx_bit),
        .locked  (locked)
    );

    bit_store #(
        .DEPTH (DEPTH),
        .RD_W  (RD_W),
        .LVL_W (LVL_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .wr_en      (wr_en),
        .wr_bit     (rx_bit),
        .rd_req     (rd_req && !clr),
        .irq_level  (irq_level),
        .rd_byte    (rd_byte),
        .level_flag (level_flag),
        .ovf_flag   (ovf_flag)
    );

    // R5
    always_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_stb && fill_en && fill_always && !clr) |-> wr_en);
endmodule

// File: tb/sync_bit_fifo_test.sv
module sync_bit_fifo_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_bit = 1'b0, bit_stb = 1'b0;
    logic       rx_en = 1'b1, fifo_en = 1'b1;
    logic       fill_en = 1'b0, fill_always = 1'b0;
    logic [3:0] irq_level = 4'd1;
    logic       rd_req = 1'b0;
    logic [7:0] rd_byte;
    logic       level_flag, ovf_flag;

    int n_run = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    sync_bit_fifo uut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_stb(bit_stb),
        .rx_en(rx_en), .fifo_en(fifo_en), .fill_en(fill_en),
        .fill_always(fill_always), .irq_level(irq_level), .rd_req(rd_req),
        .rd_byte(rd_byte), .level_flag(level_flag), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit  = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pop(output logic [7:0] b);
        @(negedge clk);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        b = rd_byte;
    endtask

    task automatic flush();
        @(negedge clk);
        fifo_en = 1'b0;
        @(negedge clk);
        fifo_en = 1'b1;
    endtask

    task automatic t_reset();
        irq_level = 4'd1;
        @(negedge clk);
        check("R1 reset level", {15'd0, level_flag}, 16'd0);
        check("R1 reset ovf", {15'd0, ovf_flag}, 16'd0);
    endtask

    task automatic t_sync();
        logic [7:0] b;
        fill_always = 1'b0;
        fill_en = 1'b1;
        irq_level = 4'd1;
        send_word(16'h00FF, 8);
        send_word(16'h2DD4, 16);
        check("R2 nothing before/at pattern", {15'd0, level_flag}, 16'd0);
        send_word(16'h00A5, 8);
        irq_level = 4'd8;
        @(negedge clk);
        check("R2 eight stored after pattern", {15'd0, level_flag}, 16'd1);
        pop(b);
        check("R10 byte order", {8'd0, b}, 16'h00A5);
        send_word(16'h2DD4, 16);
        pop(b);
        check("R3 pattern stored while locked hi", {8'd0, b}, 16'h002D);
        pop(b);
        check("R3 pattern stored while locked lo", {8'd0, b}, 16'h00D4);
    endtask

    task automatic t_rearm();
        logic [7:0] b;
        irq_level = 4'd1;
        @(negedge clk);
        fill_en = 1'b0;
        send_word(16'h003C, 8);
        check("R4 no store while fill off", {15'd0, level_flag}, 16'd0);
        fill_en = 1'b1;
        send_word(16'h0011, 8);
        check("R4 rearm needs new pattern", {15'd0, level_flag}, 16'd0);
        send_word(16'h2DD4, 16);
        send_word(16'h0077, 8);
        pop(b);
        check("R4 store after new pattern", {8'd0, b}, 16'h0077);
    endtask

    task automatic t_always();
        logic [7:0] b;
        flush();
        fill_always = 1'b1;
        fill_en = 1'b1;
        irq_level = 4'd1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_bit = ~rx_bit;
        end
        @(negedge clk);
        check("R6 no strobe no store", {15'd0, level_flag}, 16'd0);
        send_word(16'h005A, 8);
        pop(b);
        check("R5 always fill", {8'd0, b}, 16'h005A);
    endtask

    task automatic t_level_partial();
        logic [7:0] b;
        flush();
        irq_level = 4'd5;
        send_word(16'h000B, 4);
        check("R7 below threshold", {15'd0, level_flag}, 16'd0);
        send_bit(1'b0);
        check("R7 at threshold", {15'd0, level_flag}, 16'd1);
        pop(b);
        check("R11 padded byte", {8'd0, b}, 16'h00B0);
        irq_level = 4'd1;
        @(negedge clk);
        check("R11 empty after short read", {15'd0, level_flag}, 16'd0);
    endtask

    task automatic t_overflow();
        logic [7:0] b;
        flush();
        send_word(16'h1234, 16);
        check("R8 no ovf at full", {15'd0, ovf_flag}, 16'd0);
        send_bit(1'b1);
        check("R8 ovf set", {15'd0, ovf_flag}, 16'd1);
        pop(b);
        check("R8 data kept hi", {8'd0, b}, 16'h0012);
        check("R9 ovf cleared by read", {15'd0, ovf_flag}, 16'd0);
        pop(b);
        check("R8 data kept lo", {8'd0, b}, 16'h0034);
    endtask

    task automatic t_clear();
        send_word(16'hFFFF, 16);
        send_bit(1'b0);
        check("R9 ovf held", {15'd0, ovf_flag}, 16'd1);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        rx_en = 1'b1;
        irq_level = 4'd1;
        check("R1 rx_en clears count", {15'd0, level_flag}, 16'd0);
        check("R1 rx_en clears ovf", {15'd0, ovf_flag}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sync();
        t_rearm();
        t_always();
        t_level_partial();
        t_overflow();
        t_clear();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule